// File: doc/BRIEF.md
# UART Host Register Block

This block is the processor-facing register file of a 16550-compatible serial port. A host reaches it through a 3-bit offset, a read strobe, a write strobe and a byte-wide data path. The block decodes every access to one of the port's registers: receive and transmit holding bytes, interrupt enable and identification, FIFO control, line and modem control, line and modem status, a scratch byte and the 16-bit baud divisor. It also drives the single interrupt request pin.

Two details set the decode apart. Bit 7 of line control, the divisor-access bit, turns offsets 0 and 1 into the divisor bytes. Several offsets lead to one register on a read and to another on a write. The interrupt pin is gated by the OUT2 bit of modem control. The serial shifters sit outside and connect through a byte-arrival strobe, a take strobe from the transmit shifter, error pulses and modem-line inputs. The control fields go back to them as plain outputs.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, reads return interrupt enable 0x00, identification 0x01, line control 0x00, modem control 0x00, scratch 0x00, line status 0x60 when `tx_idle` is 1, and `irq` is 0.
- R2: With line-control bit 7 at 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The `divisor` output carries the value, and neither interrupt enable nor the transmit byte changes.
- R3: With line-control bit 7 at 0, a read at offset 0 returns the last received byte. A write at offset 0 loads `tx_data` and pulses `tx_start` for one cycle in the following cycle. Offset 1 is interrupt enable, with bits 3:0 stored and bits 7:4 read as 0.
- R4: A write at offset 2 stores the byte on `fifo_ctrl`. Reads at offset 2 return the identification byte, whose bits 7:6 both equal stored FIFO-control bit 0.
- R5: Offsets 3 (line control), 4 (modem control, bits 4:0 kept, 7:5 read 0) and 7 (scratch) read back what was written, whatever the divisor-access bit. Writes to offsets 5 and 6 change nothing.
- R6: `rx_load` captures `rx_byte` and sets line-status bit 0 (data ready). A read at offset 0 with the divisor-access bit at 0 clears that bit, unless a new byte arrives in the same cycle. A byte arriving while data ready is 1 sets line-status bit 1 (overrun).
- R7: A write of the transmit byte clears line-status bit 5 (holding empty). `tx_take` sets it again, and the write wins when both occur in one cycle. Bit 6 reads as bit 5 AND `tx_idle`.
- R8: `err_set` bits 0, 1 and 2 set line-status bits 2, 3 and 4, which stay set. A read at offset 5 clears bits 4:1, except bits set in that same cycle.
- R9: A read at offset 6 returns `modem_lines` in bits 7:4 and sticky change flags in bits 3:0. The flags are set by `modem_delta` and cleared by that read, except flags set in the same cycle.
- R10: Identification bits 3:0 give 0110 for line error, 0100 for data ready, 0010 for holding empty, 0000 for modem change and 0001 for none, in that priority. Each source counts only when its enable bit is set: bit 0 data, bit 1 holding empty, bit 2 line error, bit 3 modem.
- R11: `irq` is 1 exactly when modem-control bit 3 (OUT2) is 1 and some enabled source is pending. It is held at 0 while OUT2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the offset |
| irq | output | 1 | Interrupt request |
| rx_load | input | 1 | Receive shifter has a new byte |
| rx_byte | input | 8 | The new byte |
| err_set | input | 3 | Parity, framing and break error pulses |
| tx_take | input | 1 | Transmit shifter consumed the holding byte |
| tx_idle | input | 1 | Transmit shifter empty |
| tx_data | output | 8 | Transmit holding byte |
| tx_start | output | 1 | One-cycle pulse after a holding-byte write |
| modem_lines | input | 4 | Live modem input levels |
| modem_delta | input | 4 | Modem line change pulses |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 5 | Modem control register |
| fifo_ctrl | output | 8 | FIFO control register |
| divisor | output | 16 | Baud divisor |

## Verification
The bench targets the aliasing of offsets 0 and 1. A decode that ignores the divisor-access bit would overwrite interrupt enable or the transmit byte during divisor setup, or would clear data ready on a divisor read. It also tests collisions: a byte arriving during a buffer read, an error or delta arriving during its clearing read, and a write meeting a take. A block with the wrong winner would lose an event or report a stale one. Identification is walked through every priority level as sources are cleared one at a time, and the interrupt pin is watched on every cycle while OUT2 toggles. A block that leaks an ungated interrupt, or ranks two sources the wrong way, shows up at once.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int IEN_W    = 4;
  localparam int MCTL_W   = 5;
  localparam int DLAB_BIT = 7;
  localparam int OUT2_BIT = 3;

  typedef enum logic [3:0] {
    REG_NONE, REG_RBR, REG_THR, REG_IEN, REG_IID, REG_FCTL, REG_LCTL,
    REG_MCTL, REG_LSTAT, REG_MSTAT, REG_SCR, REG_DIVLO, REG_DIVHI
  } reg_id_e;

  function automatic reg_id_e map_read(logic [ADDR_W-1:0] a, logic dlab);
    case (a)
      3'd0:    return dlab ? REG_DIVLO : REG_RBR;
      3'd1:    return dlab ? REG_DIVHI : REG_IEN;
      3'd2:    return REG_IID;
      3'd3:    return REG_LCTL;
      3'd4:    return REG_MCTL;
      3'd5:    return REG_LSTAT;
      3'd6:    return REG_MSTAT;
      default: return REG_SCR;
    endcase
  endfunction

  function automatic reg_id_e map_write(logic [ADDR_W-1:0] a, logic dlab);
    case (a)
      3'd0:    return dlab ? REG_DIVLO : REG_THR;
      3'd1:    return dlab ? REG_DIVHI : REG_IEN;
      3'd2:    return REG_FCTL;
      3'd3:    return REG_LCTL;
      3'd4:    return REG_MCTL;
      3'd7:    return REG_SCR;
      default: return REG_NONE;
    endcase
  endfunction

  // pend bit order: [0] line error, [1] data ready, [2] holding empty, [3] modem
  function automatic logic [3:0] iid_code(logic [3:0] pend);
    if (pend[0])      return 4'b0110;
    else if (pend[1]) return 4'b0100;
    else if (pend[2]) return 4'b0010;
    else if (pend[3]) return 4'b0000;
    else              return 4'b0001;
  endfunction

  // sticky bit vector: clear on read, new events win
  function automatic logic [3:0] sticky_next(logic [3:0] cur, logic clr, logic [3:0] set);
    return (clr ? 4'b0000 : cur) | set;
  endfunction
endpackage

// File: rtl/urg_decode.sv
module urg_decode
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  input  logic              rd_en,
  input  logic              wr_en,
  output reg_id_e           rd_id,
  output reg_id_e           wr_id
);
  assign rd_id = rd_en ? map_read(addr, dlab)  : REG_NONE;
  assign wr_id = wr_en ? map_write(addr, dlab) : REG_NONE;

  // R5: status offsets never decode to a write target
  assert_status_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd5 || addr == 3'd6)) |-> (wr_id == REG_NONE));
  // R2: divisor targets only when the access bit is set
  assert_div_needs_dlab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id == REG_DIVLO || rd_id == REG_DIVHI || wr_id == REG_DIVLO || wr_id == REG_DIVHI) |-> dlab);
endmodule

// File: rtl/urg_irq.sv
module urg_irq
  import uart_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien,
  input  logic             line_err,
  input  logic             data_rdy,
  input  logic             hold_empty,
  input  logic             modem_chg,
  input  logic             out2,
  input  logic             fifo_en,
  output logic [3:0]       pend,
  output logic [DATA_W-1:0] iid,
  output logic             irq
);
  assign pend = {ien[3] & modem_chg, ien[1] & hold_empty, ien[0] & data_rdy, ien[2] & line_err};
  assign iid  = {fifo_en, fifo_en, 2'b00, iid_code(pend)};
  assign irq  = out2 & (|pend);

  // R10: idle code exactly when nothing enabled is pending
  assert_iid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iid[0] == (pend == 4'b0000));
  // R10: a line error outranks every other source
  assert_line_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[2] && line_err) |-> (iid[3:0] == 4'b0110));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter logic [15:0] RESET_DIVISOR = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [2:0]        err_set,
  input  logic              tx_take,
  input  logic              tx_idle,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_start,
  input  logic [3:0]        modem_lines,
  input  logic [3:0]        modem_delta,
  output logic [DATA_W-1:0] line_ctrl,
  output logic [MCTL_W-1:0] modem_ctrl,
  output logic [DATA_W-1:0] fifo_ctrl,
  output logic [2*DATA_W-1:0] divisor
);
  logic [DATA_W-1:0]   lctl_q, fctl_q, scr_q, thr_q, rbr_q;
  logic [IEN_W-1:0]    ien_q;
  logic [MCTL_W-1:0]   mctl_q;
  logic [2*DATA_W-1:0] div_q;
  logic                dr_q, thre_q, txs_q;
  logic [3:0]          lerr_q;   // [0] overrun [1] parity [2] framing [3] break
  logic [3:0]          mdel_q;
  reg_id_e             rd_id, wr_id;
  logic [3:0]          pend;
  logic [DATA_W-1:0]   iid, lstat, mstat;

  // named internal events
  wire dlab      = lctl_q[DLAB_BIT];
  wire rd_rbr    = (rd_id == REG_RBR);
  wire rd_lstat  = (rd_id == REG_LSTAT);
  wire rd_mstat  = (rd_id == REG_MSTAT);
  wire wr_thr    = (wr_id == REG_THR);
  wire overrun_ev = rx_load & dr_q;

  urg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dlab(dlab),
    .rd_en(rd_en), .wr_en(wr_en), .rd_id(rd_id), .wr_id(wr_id)
  );

  urg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ien(ien_q), .line_err(|lerr_q), .data_rdy(dr_q),
    .hold_empty(thre_q), .modem_chg(|mdel_q), .out2(mctl_q[OUT2_BIT]),
    .fifo_en(fctl_q[0]), .pend(pend), .iid(iid), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lctl_q <= '0; fctl_q <= '0; scr_q <= '0; ien_q <= '0; mctl_q <= '0;
      div_q  <= RESET_DIVISOR;
    end else begin
      case (wr_id)
        REG_LCTL:  lctl_q <= wdata;
        REG_FCTL:  fctl_q <= wdata;
        REG_SCR:   scr_q  <= wdata;
        REG_IEN:   ien_q  <= wdata[IEN_W-1:0];
        REG_MCTL:  mctl_q <= wdata[MCTL_W-1:0];
        REG_DIVLO: div_q[DATA_W-1:0] <= wdata;
        REG_DIVHI: div_q[2*DATA_W-1:DATA_W] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0; dr_q <= 1'b0; lerr_q <= '0; mdel_q <= '0;
    end else begin
      if (rx_load) begin
        rbr_q <= rx_byte;
        dr_q  <= 1'b1;
      end else if (rd_rbr) begin
        dr_q  <= 1'b0;
      end
      lerr_q <= sticky_next(lerr_q, rd_lstat, {err_set, overrun_ev});
      mdel_q <= sticky_next(mdel_q, rd_mstat, modem_delta);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0; thre_q <= 1'b1; txs_q <= 1'b0;
    end else begin
      txs_q <= wr_thr;
      if (wr_thr) begin
        thr_q  <= wdata;
        thre_q <= 1'b0;
      end else if (tx_take) begin
        thre_q <= 1'b1;
      end
    end
  end

  assign lstat = {1'b0, thre_q & tx_idle, thre_q, lerr_q, dr_q};
  assign mstat = {modem_lines, mdel_q};

  always_comb begin
    case (map_read(addr, dlab))
      REG_RBR:   rdata = rbr_q;
      REG_DIVLO: rdata = div_q[DATA_W-1:0];
      REG_DIVHI: rdata = div_q[2*DATA_W-1:DATA_W];
      REG_IEN:   rdata = {{(DATA_W-IEN_W){1'b0}}, ien_q};
      REG_IID:   rdata = iid;
      REG_LCTL:  rdata = lctl_q;
      REG_MCTL:  rdata = {{(DATA_W-MCTL_W){1'b0}}, mctl_q};
      REG_LSTAT: rdata = lstat;
      REG_MSTAT: rdata = mstat;
      default:   rdata = scr_q;
    endcase
  end

  assign tx_data    = thr_q;
  assign tx_start   = txs_q;
  assign line_ctrl  = lctl_q;
  assign modem_ctrl = mctl_q;
  assign fifo_ctrl  = fctl_q;
  assign divisor    = div_q;

  // R2: divisor untouched while the access bit is clear
  assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dlab |=> $stable(divisor));
  // R2: interrupt enable untouched while the access bit is set
  assert_ien_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dlab |=> $stable(ien_q));
  // R3: a holding write produces the start pulse next cycle
  assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> tx_start);
  // R6: arrival always leaves data ready set
  assert_dr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> lstat[0]);
  // R6: arrival on a full buffer flags overrun
  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> lstat[1]);
  // R7: a holding write empties holding-empty even against a take
  assert_thre_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> !lstat[5]);
  // R11: clearing OUT2 silences the pin
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_id == REG_MCTL && !wdata[OUT2_BIT]) |=> !irq);
endmodule

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic rd_en = 0, wr_en = 0, rx_load = 0, tx_take = 0, tx_idle = 1;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [2:0] err_set = '0;
  logic [3:0] modem_lines = '0, modem_delta = '0;
  logic [7:0] rdata, tx_data, line_ctrl, fifo_ctrl;
  logic [4:0] modem_ctrl;
  logic [15:0] divisor;
  logic irq, tx_start;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag = "";

  // behavioural reference state
  int m_lcr, m_ier, m_mcr, m_scr, m_fcr, m_div, m_thr, m_rbr;
  int m_dr, m_oe, m_pe, m_fe, m_bi, m_thre, m_msd, m_txs;

  always #10 clk = ~clk;

  uart_host_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rx_load(rx_load), .rx_byte(rx_byte),
    .err_set(err_set), .tx_take(tx_take), .tx_idle(tx_idle), .tx_data(tx_data),
    .tx_start(tx_start), .modem_lines(modem_lines), .modem_delta(modem_delta),
    .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .fifo_ctrl(fifo_ctrl), .divisor(divisor)
  );

  task automatic chk(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic int m_pend();
    int p = 0;
    if (m_ier[2] && (m_oe | m_pe | m_fe | m_bi) != 0) p |= 1;
    if (m_ier[0] && m_dr != 0) p |= 2;
    if (m_ier[1] && m_thre != 0) p |= 4;
    if (m_ier[3] && m_msd != 0) p |= 8;
    return p;
  endfunction

  function automatic int m_iid();
    int p = m_pend();
    int c;
    if (p & 1) c = 6; else if (p & 2) c = 4; else if (p & 4) c = 2; else if (p & 8) c = 0; else c = 1;
    return c | ((m_fcr & 1) ? 8'hC0 : 0);
  endfunction

  function automatic int m_read(int a);
    bit dl = m_lcr[7];
    case (a)
      0: return dl ? (m_div & 255) : m_rbr;
      1: return dl ? (m_div >> 8) : m_ier;
      2: return m_iid();
      3: return m_lcr;
      4: return m_mcr;
      5: return m_dr | (m_oe << 1) | (m_pe << 2) | (m_fe << 3) | (m_bi << 4)
                | (m_thre << 5) | ((m_thre & int'(tx_idle)) << 6);
      6: return (int'(modem_lines) << 4) | m_msd;
      default: return m_scr;
    endcase
  endfunction

  function automatic string addr_tag(int a);
    if (tag != "") return tag;
    case (a)
      0, 1: return m_lcr[7] ? "R2" : "R3";
      2: return "R10";
      5: return "R8";
      6: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic m_reset();
    m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0; m_fcr = 0; m_div = 0; m_thr = 0; m_rbr = 0;
    m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_thre = 1; m_msd = 0; m_txs = 0;
  endtask

  task automatic m_update();
    bit dl = m_lcr[7];
    bit wthr = wr_en && addr == 0 && !dl;
    bit ov = rx_load && m_dr != 0;
    if (rx_load) begin m_rbr = rx_byte; m_dr = 1; end
    else if (rd_en && addr == 0 && !dl) m_dr = 0;
    if (rd_en && addr == 5) begin m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
    if (ov) m_oe = 1;
    if (err_set[0]) m_pe = 1;
    if (err_set[1]) m_fe = 1;
    if (err_set[2]) m_bi = 1;
    if (rd_en && addr == 6) m_msd = 0;
    m_msd |= modem_delta;
    m_txs = wthr;
    if (wr_en) case (addr)
      0: if (dl) m_div = (m_div & 16'hFF00) | wdata; else m_thr = wdata;
      1: if (dl) m_div = (m_div & 16'h00FF) | (int'(wdata) << 8); else m_ier = wdata & 15;
      2: m_fcr = wdata;
      3: m_lcr = wdata;
      4: m_mcr = wdata & 31;
      7: m_scr = wdata;
      default: ;
    endcase
    if (wthr) m_thre = 0;
    else if (tx_take) m_thre = 1;
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic tick();
    #2;
    chk("R11", "irq", irq, (m_mcr[3] && m_pend() != 0) ? 1 : 0);
    chk("R2", "divisor", divisor, m_div);
    chk("R3", "tx_data", tx_data, m_thr);
    chk("R3", "tx_start", tx_start, m_txs);
    chk("R5", "line_ctrl", line_ctrl, m_lcr);
    chk("R5", "modem_ctrl", modem_ctrl, m_mcr);
    chk("R4", "fifo_ctrl", fifo_ctrl, m_fcr);
    if (rd_en) chk(addr_tag(addr), $sformatf("rdata@%0d", addr), rdata, m_read(addr));
    @(posedge clk);
    m_update();
    @(negedge clk);
    rd_en = 0; wr_en = 0; rx_load = 0; tx_take = 0; err_set = 0; modem_delta = 0;
  endtask

  task automatic wr(int a, int d);
    addr = a[2:0]; wdata = d[7:0]; wr_en = 1; tick();
  endtask
  task automatic rd(int a);
    addr = a[2:0]; rd_en = 1; tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values at every offset
    tag = "R1";
    for (int a = 0; a < 8; a++) rd(a);
    tag = "";
    // R2: divisor access and aliasing
    wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12); rd(0); rd(1); rd(3); rd(7);
    tag = "R2"; rx_byte = 8'h77; rx_load = 1; rd(0); tag = "";
    wr(3, 8'h03);
    // R3: buffer and enable under the clear bit
    rd(0); rd(1); wr(1, 8'hF0); rd(1); wr(0, 8'h5A); tick(); rd(0);
    // R4: FIFO control and identification mirror
    wr(2, 8'h01); rd(2); wr(2, 8'h00); rd(2);
    // R5: plain registers and read-only status
    wr(7, 8'hC3); wr(4, 8'hFF); rd(4); wr(4, 8'h00); rd(7);
    tag = "R5"; wr(5, 8'hFF); rd(5); wr(6, 8'hFF); rd(6); tag = "";
    // R6: arrival, clear, overrun, collision
    tag = "R6";
    rd(0); rd(5);
    rx_byte = 8'hA5; rx_load = 1; tick(); rd(5); rd(0); rd(5);
    rx_byte = 8'h11; rx_load = 1; tick(); rx_byte = 8'h22; rx_load = 1; tick(); rd(5); rd(5);
    rx_byte = 8'h33; rx_load = 1; addr = 0; rd_en = 1; tick(); rd(5); rd(0);
    // R7: holding empty, take, collision, idle
    tag = "R7";
    wr(0, 8'h01); rd(5); tx_take = 1; tick(); rd(5);
    wr(0, 8'h02); tx_take = 1; addr = 0; wdata = 8'h03; wr_en = 1; tick(); rd(5);
    tx_idle = 0; tx_take = 1; tick(); rd(5); tx_idle = 1; rd(5);
    // R8: sticky errors and clear collision
    tag = "R8";
    err_set = 3'b001; tick(); rd(5); rd(5);
    err_set = 3'b110; tick(); err_set = 3'b010; addr = 5; rd_en = 1; tick(); rd(5); rd(5);
    // R9: modem status
    tag = "R9";
    modem_lines = 4'hA; modem_delta = 4'h5; tick(); rd(6); rd(6);
    modem_delta = 4'h2; addr = 6; rd_en = 1; tick(); rd(6); rd(6);
    // R10 / R11: priorities and gating
    tag = "R10";
    wr(1, 8'h0F); rd(2);
    rx_byte = 8'h44; rx_load = 1; err_set = 3'b100; modem_delta = 4'h1; wr(0, 8'h09);
    rd(2); wr(4, 8'h08); rd(2); rd(5); rd(2); rd(0); rd(2); rd(6); rd(2);
    tx_take = 1; tick(); rd(2);
    tag = "R11";
    wr(4, 8'h00); tick(); wr(4, 8'h08); tick(); wr(1, 8'h00); tick(); wr(1, 8'h02); tick();
    modem_delta = 4'h8; wr(1, 8'h08); rd(6); tick();
    tag = "";
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule